// File: doc/BRIEF.md
# Virtual Interface Maintenance Interrupt Controller

This block sits beside a virtual interrupt CPU interface. It holds the hypervisor's control word for that interface and turns a set of conditions into one level-sensitive maintenance interrupt. The control word has an enable bit for each of seven conditions and a single master enable. Its upper bits hold a 5-bit counter. The counter tracks end-of-interrupt events that found no matching list entry.

The surrounding logic supplies several inputs. These are summary masks of which list entries are valid and which are pending, the guest's group 0 and group 1 enable bits, and a strobe for each end-of-interrupt event with two qualifiers. The hypervisor reads and writes the control word through a plain single-register port. The block reports each active condition on its own status bit, before the master enable is applied. The interrupt itself comes from a flop.

Top module: `vif_maint_ctrl`

## Requirements
- R1: After reset every control bit and the counter are 0, and `maint_irq` is 0. The read word has the following layout. Bits 31:27 hold the counter and bits 26:8 always read 0. From bit 7 down to bit 0 are: group-1-off enable, group-1-on enable, group-0-off enable, group-0-on enable, no-pending enable, missing-entry enable, underflow enable, and master enable. A write with `reg_we` high appears on `reg_rdata` from the following cycle.
- R2: The counter advances by 1 on a clock edge only when `eoi_valid`, `eoi_no_entry` and `eoi_apr_clr` are all high. An event that lacks either qualifier leaves the counter unchanged.
- R3: A counted event when the counter is 31 makes it 0.
- R4: If a write and a counted event fall on the same edge, the counter takes the written bits 31:27 and the increment is lost.
- R5: `cause_status[1]` (missing entry) is high when control bit 2 is set and the counter is nonzero.
- R6: `cause_status[2]` (no pending) is high when control bit 3 is set and `lr_pending` is all zeros.
- R7: `cause_status[0]` (underflow) is high when control bit 1 is set and at most one bit of `lr_valid` is set.
- R8: For the group conditions, status bit 3 is control bit 4 AND `guest_g0_en`. Status bit 4 is control bit 5 AND NOT `guest_g0_en`. Status bit 5 is control bit 6 AND `guest_g1_en`. Status bit 6 is control bit 7 AND NOT `guest_g1_en`.
- R9: `maint_irq` in a cycle equals the master enable AND the OR of `cause_status` from the previous cycle. When the master enable is 0, `maint_irq` stays 0.
- R10: `cause_status` does not depend on the master enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control word, reserved bits zero |
| lr_valid | input | 4 | One bit per list entry holding a valid interrupt |
| lr_pending | input | 4 | One bit per list entry in the pending state |
| guest_g0_en | input | 1 | Guest's group 0 signalling enable |
| guest_g1_en | input | 1 | Guest's group 1 signalling enable |
| eoi_valid | input | 1 | End-of-interrupt event strobe |
| eoi_no_entry | input | 1 | Event found no matching list entry |
| eoi_apr_clr | input | 1 | Event cleared an active-priority bit |
| cause_status | output | 7 | Active conditions, before the master enable |
| maint_irq | output | 1 | Registered maintenance interrupt |

## Verification
Each output has its own timing. `cause_status` is combinational from the stored word and the live inputs, so it is due in the same cycle the inputs change. Writes and counted events show on `reg_rdata` one edge later. `maint_irq` lags `cause_status` by exactly one edge. The bench drives inputs 2 ns after a rising edge and compares every output at the falling edge. It uses a behavioural model that updates on the same rising edge, so each comparison lines up with these delays. Directed sequences cover the points that per-cycle comparison alone may not reach: the counter wrap, the write/event collision, disqualified events, and causes present while the master enable is off.

// File: rtl/vif_maint_pkg.sv
package vif_maint_pkg;

   localparam int NUM_CAUSES = 7;
   localparam int CTL_W      = 8;

   // status vector positions; each matches control bit (position + 1)
   typedef enum int {
      C_UNDERFLOW = 0,
      C_NO_ENTRY  = 1,
      C_NO_PEND   = 2,
      C_G0_ON     = 3,
      C_G0_OFF    = 4,
      C_G1_ON     = 5,
      C_G1_OFF    = 6
   } cause_e;

   typedef struct packed {
      logic g1_off_ie;
      logic g1_on_ie;
      logic g0_off_ie;
      logic g0_on_ie;
      logic nopend_ie;
      logic noentry_ie;
      logic under_ie;
      logic enable;
   } ctl_t;

endpackage

// File: rtl/vif_ctl_regs.sv
module vif_ctl_regs
   import vif_maint_pkg::*;
#(
   parameter int REG_W   = 32,
   parameter int CNT_W   = 5,
   parameter int CNT_LSB = 27
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   input  logic             cnt_inc,
   output ctl_t             ctl,
   output logic [CNT_W-1:0] eoi_cnt,
   output logic [REG_W-1:0] rdata
);

   localparam int CNT_MSB = CNT_LSB + CNT_W - 1;

   if (CNT_MSB >= REG_W) begin : g_bad_cnt_pos
      $error("counter field does not fit in the register");
   end
   if (CNT_LSB < CTL_W) begin : g_bad_cnt_overlap
      $error("counter field overlaps the control bits");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl     <= '0;
         eoi_cnt <= '0;
      end else if (we) begin
         ctl     <= ctl_t'(wdata[CTL_W-1:0]);
         eoi_cnt <= wdata[CNT_MSB:CNT_LSB];
      end else if (cnt_inc) begin
         eoi_cnt <= eoi_cnt + CNT_W'(1);
      end
   end

   always_comb begin
      rdata                   = '0;
      rdata[CTL_W-1:0]        = ctl;
      rdata[CNT_MSB:CNT_LSB]  = eoi_cnt;
   end

endmodule

// File: rtl/vif_cause_eval.sv
module vif_cause_eval
   import vif_maint_pkg::*;
#(
   parameter int NUM_ENTRIES = 4,
   parameter int CNT_W       = 5,
   parameter int UNDER_MAX   = 1
) (
   input  ctl_t                   ctl,
   input  logic [CNT_W-1:0]       eoi_cnt,
   input  logic [NUM_ENTRIES-1:0] lr_valid,
   input  logic [NUM_ENTRIES-1:0] lr_pending,
   input  logic                   g0_en,
   input  logic                   g1_en,
   output logic [NUM_CAUSES-1:0]  status
);

   localparam int POP_W = $clog2(NUM_ENTRIES + 1);

   if (NUM_ENTRIES < 1) begin : g_bad_entries
      $error("at least one list entry is required");
   end

   logic few_valid;

   if (NUM_ENTRIES <= UNDER_MAX) begin : g_few_always
      assign few_valid = 1'b1;
   end else begin : g_few_popcount
      logic [POP_W-1:0] vcount;
      always_comb begin
         vcount = '0;
         for (int i = 0; i < NUM_ENTRIES; i++) begin
            vcount = vcount + POP_W'(lr_valid[i]);
         end
      end
      assign few_valid = (vcount <= POP_W'(UNDER_MAX));
   end

   always_comb begin
      status            = '0;
      status[C_UNDERFLOW] = ctl.under_ie   & few_valid;
      status[C_NO_ENTRY]  = ctl.noentry_ie & (eoi_cnt != '0);
      status[C_NO_PEND]   = ctl.nopend_ie  & ~(|lr_pending);
      status[C_G0_ON]     = ctl.g0_on_ie   & g0_en;
      status[C_G0_OFF]    = ctl.g0_off_ie  & ~g0_en;
      status[C_G1_ON]     = ctl.g1_on_ie   & g1_en;
      status[C_G1_OFF]    = ctl.g1_off_ie  & ~g1_en;
   end

endmodule

// File: rtl/vif_irq_out.sv
module vif_irq_out #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         enable,
   input  logic [N-1:0] status,
   output logic         irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= enable & (|status);
   end

endmodule

// File: rtl/vif_maint_ctrl.sv
module vif_maint_ctrl
   import vif_maint_pkg::*;
#(
   parameter int REG_W       = 32,
   parameter int CNT_W       = 5,
   parameter int CNT_LSB     = 27,
   parameter int NUM_ENTRIES = 4,
   parameter int UNDER_MAX   = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_we,
   input  logic [REG_W-1:0]       reg_wdata,
   output logic [REG_W-1:0]       reg_rdata,
   input  logic [NUM_ENTRIES-1:0] lr_valid,
   input  logic [NUM_ENTRIES-1:0] lr_pending,
   input  logic                   guest_g0_en,
   input  logic                   guest_g1_en,
   input  logic                   eoi_valid,
   input  logic                   eoi_no_entry,
   input  logic                   eoi_apr_clr,
   output logic [NUM_CAUSES-1:0]  cause_status,
   output logic                   maint_irq
);

   ctl_t             ctl;
   logic [CNT_W-1:0] eoi_cnt;
   logic             cnt_inc;

   assign cnt_inc = eoi_valid & eoi_no_entry & eoi_apr_clr;

   vif_ctl_regs #(
      .REG_W   (REG_W),
      .CNT_W   (CNT_W),
      .CNT_LSB (CNT_LSB)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (reg_we),
      .wdata   (reg_wdata),
      .cnt_inc (cnt_inc),
      .ctl     (ctl),
      .eoi_cnt (eoi_cnt),
      .rdata   (reg_rdata)
   );

   vif_cause_eval #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .CNT_W       (CNT_W),
      .UNDER_MAX   (UNDER_MAX)
   ) u_eval (
      .ctl        (ctl),
      .eoi_cnt    (eoi_cnt),
      .lr_valid   (lr_valid),
      .lr_pending (lr_pending),
      .g0_en      (guest_g0_en),
      .g1_en      (guest_g1_en),
      .status     (cause_status)
   );

   vif_irq_out #(
      .N (NUM_CAUSES)
   ) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (ctl.enable),
      .status (cause_status),
      .irq    (maint_irq)
   );

endmodule

// File: rtl/vif_maint_checker.sv
module vif_maint_checker #(
   parameter int REG_W   = 32,
   parameter int CNT_W   = 5,
   parameter int CNT_LSB = 27,
   parameter int NC      = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic [REG_W-1:0] reg_wdata,
   input logic [REG_W-1:0] reg_rdata,
   input logic             eoi_valid,
   input logic             eoi_no_entry,
   input logic             eoi_apr_clr,
   input logic [NC-1:0]    cause_status,
   input logic             maint_irq
);

   logic [CNT_W-1:0] cnt;
   logic [REG_W-1:0] keep_mask;
   logic             counted;

   assign cnt     = reg_rdata[CNT_LSB +: CNT_W];
   assign counted = eoi_valid & eoi_no_entry & eoi_apr_clr;

   always_comb begin
      keep_mask                   = '0;
      keep_mask[7:0]              = '1;
      keep_mask[CNT_LSB +: CNT_W] = '1;
   end

   // R2 and R3: a counted event steps the counter by one, modulo its width
   a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_we && counted) |=> (cnt == $past(cnt) + CNT_W'(1)));

   // R2: without a full qualifier set the counter holds
   a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_we && !counted) |=> $stable(cnt));

   // R4 and R1: the written value lands, whatever the event inputs do
   a_r4_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> (reg_rdata == ($past(reg_wdata) & $past(keep_mask))));

   // R1: reserved field reads zero
   a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata & ~keep_mask) == '0);

   // R5: missing-entry cause implies a nonzero counter
   a_r5_noentry_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
      cause_status[1] |-> (cnt != '0));

   // R9: master enable off means no interrupt next cycle
   a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[0] |=> !maint_irq);

   // R9: an enabled active cause raises the interrupt next cycle
   a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[0] && (|cause_status)) |=> maint_irq);

endmodule

bind vif_maint_ctrl vif_maint_checker #(
   .REG_W   (REG_W),
   .CNT_W   (CNT_W),
   .CNT_LSB (CNT_LSB),
   .NC      (vif_maint_pkg::NUM_CAUSES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_we       (reg_we),
   .reg_wdata    (reg_wdata),
   .reg_rdata    (reg_rdata),
   .eoi_valid    (eoi_valid),
   .eoi_no_entry (eoi_no_entry),
   .eoi_apr_clr  (eoi_apr_clr),
   .cause_status (cause_status),
   .maint_irq    (maint_irq)
);

// File: tb/vif_maint_ctrl_bench.sv
`timescale 1ns/1ps
module vif_maint_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  lr_valid = '0;
   logic [3:0]  lr_pending = '0;
   logic        guest_g0_en = 1'b0;
   logic        guest_g1_en = 1'b0;
   logic        eoi_valid = 1'b0;
   logic        eoi_no_entry = 1'b0;
   logic        eoi_apr_clr = 1'b0;
   logic [6:0]  cause_status;
   logic        maint_irq;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   vif_maint_ctrl u_vif_maint_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_we       (reg_we),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .lr_valid     (lr_valid),
      .lr_pending   (lr_pending),
      .guest_g0_en  (guest_g0_en),
      .guest_g1_en  (guest_g1_en),
      .eoi_valid    (eoi_valid),
      .eoi_no_entry (eoi_no_entry),
      .eoi_apr_clr  (eoi_apr_clr),
      .cause_status (cause_status),
      .maint_irq    (maint_irq)
   );

   // ---------------- reference model ----------------
   logic [7:0] m_ctl = '0;
   logic [4:0] m_cnt = '0;
   logic       m_irq = 1'b0;

   function automatic logic [6:0] model_causes();
      logic [6:0] c;
      c[0] = m_ctl[1] && ($countones(lr_valid) <= 1);
      c[1] = m_ctl[2] && (m_cnt != 0);
      c[2] = m_ctl[3] && (lr_pending == 4'b0);
      c[3] = m_ctl[4] && guest_g0_en;
      c[4] = m_ctl[5] && !guest_g0_en;
      c[5] = m_ctl[6] && guest_g1_en;
      c[6] = m_ctl[7] && !guest_g1_en;
      return c;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ctl = '0;
         m_cnt = '0;
         m_irq = 1'b0;
      end else begin
         m_irq = m_ctl[0] && (model_causes() != 7'b0);
         if (reg_we) begin
            m_ctl = reg_wdata[7:0];
            m_cnt = reg_wdata[31:27];
         end else if (eoi_valid && eoi_no_entry && eoi_apr_clr) begin
            m_cnt = m_cnt + 5'd1;
         end
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison at the falling edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         logic [6:0] ec;
         ec = model_causes();
         chk("R1 control bits", {24'b0, reg_rdata[7:0]}, {24'b0, m_ctl});
         chk("R1 reserved",     {13'b0, reg_rdata[26:8]}, 32'b0);
         chk("R2 counter",      {27'b0, reg_rdata[31:27]}, {27'b0, m_cnt});
         chk("R7 underflow",    {31'b0, cause_status[0]}, {31'b0, ec[0]});
         chk("R5 missing entry",{31'b0, cause_status[1]}, {31'b0, ec[1]});
         chk("R6 no pending",   {31'b0, cause_status[2]}, {31'b0, ec[2]});
         chk("R8 group causes", {28'b0, cause_status[6:3]}, {28'b0, ec[6:3]});
         chk("R9 irq",          {31'b0, maint_irq}, {31'b0, m_irq});
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic idle_inputs();
      reg_we = 1'b0;
      eoi_valid = 1'b0;
      eoi_no_entry = 1'b0;
      eoi_apr_clr = 1'b0;
   endtask

   task automatic write_reg(logic [31:0] d);
      reg_we = 1'b1;
      reg_wdata = d;
      step();
      reg_we = 1'b0;
   endtask

   task automatic eoi(logic ne, logic apr);
      eoi_valid = 1'b1;
      eoi_no_entry = ne;
      eoi_apr_clr = apr;
      step();
      idle_inputs();
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         failures++;
         $display("FAIL watchdog R9 actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset rdata", reg_rdata, 32'h0);
      chk("R1 reset irq", {31'b0, maint_irq}, 32'h0);
      step();
      rst_n = 1'b1;
      step();

      // all condition enables plus master enable, sweep the condition inputs
      write_reg(32'h0000_00FF);
      for (int v = 0; v < 16; v++) begin
         for (int g = 0; g < 4; g++) begin
            lr_valid = 4'(v);
            lr_pending = 4'(15 - v);
            guest_g0_en = g[0];
            guest_g1_en = g[1];
            step();
         end
      end

      // R7 boundary: two valid entries clears underflow
      write_reg(32'h0000_0002);
      lr_valid = 4'b0101;
      step();
      @(negedge clk);
      chk("R7 two valid", {31'b0, cause_status[0]}, 32'h0);
      lr_valid = 4'b1000;
      step();
      @(negedge clk);
      chk("R7 one valid", {31'b0, cause_status[0]}, 32'h1);

      // R1: reserved bits written as ones read back zero; master enable off
      write_reg(32'hFFFF_FFFE);
      @(negedge clk);
      chk("R1 layout", reg_rdata, 32'hF800_00FE);
      step();
      @(negedge clk);
      chk("R10 status ungated", {31'b0, cause_status[1]}, 32'h1);
      chk("R9 gated off", {31'b0, maint_irq}, 32'h0);

      // R3: counter at 31 wraps on a counted event
      eoi(1'b1, 1'b1);
      @(negedge clk);
      chk("R3 wrap", {27'b0, reg_rdata[31:27]}, 32'h0);

      // R2: disqualified events are ignored
      write_reg(32'h0000_0005);
      eoi(1'b1, 1'b0);
      @(negedge clk);
      chk("R2 no apr clear", {27'b0, reg_rdata[31:27]}, 32'h0);
      eoi(1'b0, 1'b1);
      @(negedge clk);
      chk("R2 entry found", {27'b0, reg_rdata[31:27]}, 32'h0);
      chk("R9 idle irq", {31'b0, maint_irq}, 32'h0);
      eoi(1'b1, 1'b1);
      @(negedge clk);
      chk("R2 counted", {27'b0, reg_rdata[31:27]}, 32'h1);
      chk("R5 active", {31'b0, cause_status[1]}, 32'h1);
      step();
      @(negedge clk);
      chk("R9 raised", {31'b0, maint_irq}, 32'h1);

      // many counted events, passing through the wrap
      for (int k = 0; k < 40; k++) eoi(1'b1, 1'b1);

      // R4: write and counted event on one edge
      eoi_valid = 1'b1;
      eoi_no_entry = 1'b1;
      eoi_apr_clr = 1'b1;
      write_reg(32'h1800_0005);
      idle_inputs();
      @(negedge clk);
      chk("R4 write wins", {27'b0, reg_rdata[31:27]}, 32'h3);

      // random phase
      for (int k = 0; k < 400; k++) begin
         logic [31:0] r;
         r = $urandom;
         lr_valid = r[3:0];
         lr_pending = r[7:4];
         guest_g0_en = r[8];
         guest_g1_en = r[9];
         eoi_valid = r[10] | r[11];
         eoi_no_entry = r[12] | r[13];
         eoi_apr_clr = r[14] | r[15];
         reg_we = (r[18:16] == 3'd0);
         reg_wdata = $urandom;
         step();
      end
      idle_inputs();
      step();
      step();

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule